// File: doc/BRIEF.md
# Audio Sample Format Converter

This block sits between an audio device and a routing fabric. It takes a stream of channel samples, one per beat, and changes their bit width and their channel count according to a packed 32-bit control word. Both streams use a valid/ready handshake. Each sample is left-justified in a 32-bit word, so a sample of width W uses bits 31 down to 32-W.

The control word gives an audio-side format and a client-side format. Each format is a channel count and a sample width. The direction bit decides which format describes the input and which describes the output. When the width grows, the new low bits are filled with zeros, with ones, or with dither from a 16-bit LFSR. When the width shrinks, the sample is either chopped or rounded. A two-channel input going to a one-channel output is mixed down. A one-channel input going to a two-channel output is expanded to two channels. In every other case the samples pass through, and the frames are counted on the output channel count. The control word is assumed to be held constant between resets.

Top module: `cif_fmt_conv`

## Requirements
- R1: Reset is synchronous and active low. On the first cycle after reset, out_valid is 0 and in_ready is 1.
- R2: Control word fields: audio channels minus one at bits 26:24, client channels minus one at 18:16, audio width code at 14:12, client width code at 10:8. A width code n means 4*(n+1) bits. When the two widths are equal, the output equals the input with every bit below the width cleared.
- R3: When the output is wider, the kept bits are the top input-width bits. Expand field bits 7:6 = 0 sets every added bit to 0. Expand = 1 sets every added bit to 1. All bits below the output width are 0.
- R4: Expand = 2 takes the added bits from the 32-bit pattern formed by the LFSR state written twice, shifted right by the input width. The LFSR is a 16-bit Fibonacci register with feedback from bits 15, 13, 12 and 10. It is seeded with 0xACE1 at reset and steps once for every output beat registered.
- R5: When the output is narrower and bit 1 = 1 (chop), the output is the top output-width bits of the input, with all lower bits 0.
- R6: When the output is narrower and bit 1 = 0 (round), half of the lowest kept bit is added to the signed value before the cut. A positive overflow saturates to the largest signed value of the output width.
- R7: With 2 input channels and 1 output channel, each pair of input beats gives one output beat, taken before width conversion. Bits 5:4 select it: 0 picks the first beat, 1 picks the second beat, 2 picks the signed 33-bit sum shifted right by one. Every output beat has out_last = 1.
- R8: With 1 input channel and 2 output channels, each input beat gives two output beats. The first is the converted sample with out_last = 0. The second has out_last = 1 and is either 0 (bit 0 = 0) or an exact copy of the first (bit 0 = 1).
- R9: For any other pair of channel counts, each input beat gives one output beat. out_last is 1 on every beat whose number, counted from reset, is a multiple of the output channel count.
- R10: Bit 2 = 0 makes the input use the audio format and the output use the client format. Bit 2 = 1 swaps them.
- R11: The threshold field (bits 31:28) and the replicate bit (bit 3) have no effect on the output stream.
- R12: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values. No sample is lost or duplicated under any backpressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 32 | Packed format control word |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Converter accepts the input sample |
| in_data | input | 32 | Left-justified input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | 32 | Left-justified output sample |
| out_last | output | 1 | Last channel beat of an output frame |

## Verification
A wrong LFSR state shows up in the low bits of the very next dithered output beat, and it stays wrong for the rest of the run. A frame counter or hold flag left in the wrong phase makes out_last land on the wrong beat, or pairs the wrong samples for mix-down. This is visible at the first affected output, within one frame. A bad rounding carry or a wrong saturation limit shows up at the first sample near full scale, so the reference model is fed those values directly, and its every-beat comparison also covers stalls under heavy backpressure.

// File: rtl/cif_fmt_pkg.sv
// Shared constants, control word field positions and helpers for the
// sample format converter. Samples are left-justified in SMP_W bits.
package cif_fmt_pkg;
    localparam int SMP_W    = 32;   // sample container width
    localparam int WCODE_W  = 3;    // width-code field size
    localparam int CCODE_W  = 3;    // channel-count field size
    localparam int CNT_W    = CCODE_W + 1;
    localparam int WID_W    = 6;    // holds a width of up to 32
    localparam int DITHER_W = 16;

    // control word field positions (other blocks decode the same word)
    localparam int F_AUD_CH   = 24;
    localparam int F_CLI_CH   = 16;
    localparam int F_AUD_BITS = 12;
    localparam int F_CLI_BITS = 8;
    localparam int F_EXPAND   = 6;
    localparam int F_STSEL    = 4;
    localparam int F_DIR      = 2;
    localparam int F_CHOP     = 1;
    localparam int F_MONO     = 0;

    typedef enum logic [1:0] {CH_PASS, CH_DOWN, CH_UP} ch_mode_e;

    // width in bits for a code n: 4*(n+1)
    function automatic logic [WID_W-1:0] code_to_width(input logic [WCODE_W-1:0] code);
        return {1'b0, code, 2'b00} + WID_W'(4);
    endfunction

    // mask covering the top w bits of a sample
    function automatic logic [SMP_W-1:0] keep_mask(input logic [WID_W-1:0] w);
        return {SMP_W{1'b1}} << (WID_W'(SMP_W) - w);
    endfunction
endpackage

// File: rtl/cif_dither_lfsr.sv
// 16-bit maximal-length Fibonacci LFSR used as the dither source.
// Assumes step is asserted once per registered output beat.
module cif_dither_lfsr
    import cif_fmt_pkg::*;
#(
    parameter logic [DITHER_W-1:0] SEED = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [DITHER_W-1:0] state
);
    // advance the register by one position per step
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= {state[DITHER_W-2:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
    end

    // R4
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/cif_chan_mix.sv
// Mix-down selector for two-channel to one-channel conversion.
// Picks the first beat, the second beat, or their signed average.
// Assumes both samples use the same left-justified format.
module cif_chan_mix
    import cif_fmt_pkg::*;
(
    input  logic [SMP_W-1:0] first_i,
    input  logic [SMP_W-1:0] second_i,
    input  logic [1:0]       sel,
    output logic [SMP_W-1:0] mix_o
);
    logic [SMP_W:0] sum;

    // widen to 33 bits, add, and shift right arithmetically by one
    always_comb begin
        sum = {first_i[SMP_W-1], first_i} + {second_i[SMP_W-1], second_i};
        unique case (sel)
            2'd1:    mix_o = second_i;
            2'd2:    mix_o = sum[SMP_W:1];
            default: mix_o = first_i;
        endcase
    end
endmodule

// File: rtl/cif_width_conv.sv
// Combinational sample width converter. It widens with a selectable fill
// and narrows by chopping or by rounding with saturation.
// Assumes widths from 4 to 32 bits, left-justified in the container.
module cif_width_conv
    import cif_fmt_pkg::*;
(
    input  logic [SMP_W-1:0]    smp_i,
    input  logic [WID_W-1:0]    win,
    input  logic [WID_W-1:0]    wout,
    input  logic [1:0]          expand,
    input  logic                chop,
    input  logic [DITHER_W-1:0] dither,
    output logic [SMP_W-1:0]    smp_o
);
    logic [SMP_W-1:0] in_mask, out_mask, kept, fill, half;
    logic [SMP_W:0]   rsum;
    logic             pos_ovf;

    // choose widen, narrow or equal path
    always_comb begin
        in_mask  = keep_mask(win);
        out_mask = keep_mask(wout);
        kept     = smp_i & in_mask;
        unique case (expand)
            2'd1:    fill = '1;
            2'd2:    fill = {dither, dither} >> win;
            default: fill = '0;
        endcase
        half    = SMP_W'(1) << (WID_W'(SMP_W - 1) - wout);
        rsum    = {kept[SMP_W-1], kept} + {1'b0, half};
        pos_ovf = !kept[SMP_W-1] && rsum[SMP_W-1];
        if (wout > win)
            smp_o = kept | (fill & out_mask & ~in_mask);
        else if (wout < win)
            smp_o = chop    ? (kept & out_mask) :
                    pos_ovf ? ({1'b0, {(SMP_W-1){1'b1}}} & out_mask) :
                              (rsum[SMP_W-1:0] & out_mask);
        else
            smp_o = kept;
    end

    // rounding a non-negative sample never makes it negative
    always_comb begin
        if (wout < win && !chop && !smp_i[SMP_W-1]) begin
            // R6
            round_sign_chk: assert (!smp_o[SMP_W-1]);
        end
    end
endmodule

// File: rtl/cif_fmt_conv.sv
// Streaming sample format converter between an audio device and a routing
// fabric. It decodes the control word, picks the channel mode, converts
// the width and registers one output beat.
// Assumes cfg is constant between resets.
module cif_fmt_conv
    import cif_fmt_pkg::*;
#(
    parameter logic [DITHER_W-1:0] DITHER_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last
);
    logic                dir_rx;
    logic [WCODE_W-1:0]  in_wcode, out_wcode;
    logic [CCODE_W-1:0]  in_ccode, out_ccode;
    logic [WID_W-1:0]    in_w, out_w;
    logic [CNT_W-1:0]    in_n, out_n;
    ch_mode_e            mode;
    logic                cfg_unused;

    logic [SMP_W-1:0]    hold_q, dup_q, mix_y, conv_in, conv_y;
    logic                hold_v, dup_pend;
    logic [CNT_W-1:0]    pcnt;
    logic [DITHER_W-1:0] dither;
    logic                can_load, in_fire, load_new, load_dup, load, nxt_last;

    assign cfg_unused = ^{cfg[31:27], cfg[23:19], cfg[15], cfg[11], cfg[3]};

    // decode the formats of each side and the channel mode
    always_comb begin
        dir_rx    = cfg[F_DIR];
        in_wcode  = dir_rx ? cfg[F_CLI_BITS +: WCODE_W] : cfg[F_AUD_BITS +: WCODE_W];
        out_wcode = dir_rx ? cfg[F_AUD_BITS +: WCODE_W] : cfg[F_CLI_BITS +: WCODE_W];
        in_ccode  = dir_rx ? cfg[F_CLI_CH +: CCODE_W]   : cfg[F_AUD_CH +: CCODE_W];
        out_ccode = dir_rx ? cfg[F_AUD_CH +: CCODE_W]   : cfg[F_CLI_CH +: CCODE_W];
        in_w      = code_to_width(in_wcode);
        out_w     = code_to_width(out_wcode);
        in_n      = CNT_W'(in_ccode) + CNT_W'(1);
        out_n     = CNT_W'(out_ccode) + CNT_W'(1);
        if (in_n == CNT_W'(2) && out_n == CNT_W'(1))
            mode = CH_DOWN;
        else if (in_n == CNT_W'(1) && out_n == CNT_W'(2))
            mode = CH_UP;
        else
            mode = CH_PASS;
    end

    cif_chan_mix u_mix (
        .first_i  (hold_q),
        .second_i (in_data),
        .sel      (cfg[F_STSEL +: 2]),
        .mix_o    (mix_y)
    );

    assign conv_in = (mode == CH_DOWN) ? mix_y : in_data;

    cif_width_conv u_wconv (
        .smp_i  (conv_in),
        .win    (in_w),
        .wout   (out_w),
        .expand (cfg[F_EXPAND +: 2]),
        .chop   (cfg[F_CHOP]),
        .dither (dither),
        .smp_o  (conv_y)
    );

    cif_dither_lfsr #(.SEED(DITHER_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (load),
        .state (dither)
    );

    // handshake and load decisions
    always_comb begin
        can_load = !out_valid || out_ready;
        unique case (mode)
            CH_DOWN: in_ready = hold_v ? can_load : 1'b1;
            CH_UP:   in_ready = !dup_pend && can_load;
            default: in_ready = can_load;
        endcase
        in_fire  = in_valid && in_ready;
        load_new = in_fire && !(mode == CH_DOWN && !hold_v);
        load_dup = (mode == CH_UP) && dup_pend && can_load;
        load     = load_new || load_dup;
        if (load_dup || mode == CH_DOWN)
            nxt_last = 1'b1;
        else if (mode == CH_UP)
            nxt_last = 1'b0;
        else
            nxt_last = (pcnt == out_n - CNT_W'(1));
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_dup ? dup_q : conv_y;
            out_last  <= nxt_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // first-channel holding for mix-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (mode == CH_DOWN && in_fire) begin
            hold_v <= !hold_v;
            if (!hold_v)
                hold_q <= in_data;
        end
    end

    // pending second beat for mono expansion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_pend <= 1'b0;
            dup_q    <= '0;
        end else if (mode == CH_UP && in_fire) begin
            dup_pend <= 1'b1;
            dup_q    <= cfg[F_MONO] ? conv_y : '0;
        end else if (load_dup) begin
            dup_pend <= 1'b0;
        end
    end

    // output-side frame position for pass-through
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (mode == CH_PASS && load_new)
            pcnt <= nxt_last ? '0 : pcnt + CNT_W'(1);
    end

    // checker state: beats delivered since the last frame end
    logic [CNT_W-1:0] chk_beats;
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_beats <= '0;
        else if (out_valid && out_ready)
            chk_beats <= out_last ? '0 : chk_beats + CNT_W'(1);
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !hold_v && !dup_pend));
    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R9
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |-> (chk_beats < out_n));
endmodule

// File: tb/cif_fmt_conv_tb.sv
// Self-checking bench. A behavioural reference model predicts every
// output beat when an input beat is accepted, and output beats are
// compared as they are delivered.
module cif_fmt_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg;
    logic        in_valid, in_ready, out_valid, out_ready, out_last;
    logic [31:0] in_data, out_data;

    always #5 clk = ~clk;

    cif_fmt_conv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int          n_cmp = 0, n_bad = 0;
    string       tag;
    logic [31:0] q_d[$];
    logic        q_l[$];
    logic [31:0] dq[$];
    bit          in_fired;

    // model state
    int          m_in_n, m_out_n, m_win, m_wout, m_exp, m_sel, m_mode;
    bit          m_chop, m_mono, m_hv;
    logic [15:0] m_lfsr;
    logic [31:0] m_hold;
    int          m_pcnt;

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] bmask(int w);
        return 32'hFFFF_FFFF << (32 - w);
    endfunction

    function automatic logic [31:0] m_width(logic [31:0] x);
        logic [31:0] xm, f;
        longint v;
        xm = x & bmask(m_win);
        if (m_wout > m_win) begin
            if (m_exp == 1) f = 32'hFFFF_FFFF;
            else if (m_exp == 2) f = {m_lfsr, m_lfsr} >> m_win;
            else f = 0;
            return xm | (f & bmask(m_wout) & ~bmask(m_win));
        end else if (m_wout < m_win) begin
            if (m_chop) return xm & bmask(m_wout);
            v = longint'($signed(xm)) + (64'sd1 <<< (31 - m_wout));
            if (v > 64'sd2147483647) v = 64'sd2147483647;
            return v[31:0] & bmask(m_wout);
        end
        return xm;
    endfunction

    task automatic m_push(logic [31:0] d, logic l);
        q_d.push_back(d);
        q_l.push_back(l);
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    endtask

    task automatic m_in(logic [31:0] x);
        logic [31:0] v;
        longint s;
        if (m_mode == 1) begin
            if (!m_hv) begin
                m_hold = x;
                m_hv = 1;
            end else begin
                if (m_sel == 1) v = x;
                else if (m_sel == 2) begin
                    s = (longint'($signed(m_hold)) + longint'($signed(x))) >>> 1;
                    v = s[31:0];
                end else v = m_hold;
                m_push(m_width(v), 1'b1);
                m_hv = 0;
            end
        end else if (m_mode == 2) begin
            v = m_width(x);
            m_push(v, 1'b0);
            m_push(m_mono ? v : 32'h0, 1'b1);
        end else begin
            m_push(m_width(x), (m_pcnt == m_out_n - 1));
            m_pcnt = (m_pcnt == m_out_n - 1) ? 0 : m_pcnt + 1;
        end
    endtask

    function automatic logic [31:0] mk(int ach, int cch, int ab, int cb, int ex, int st,
                                       int dir, int tr, int mo, int thr, int rep);
        logic [31:0] c = 0;
        c[31:28] = 4'(thr);
        c[26:24] = 3'(ach - 1);
        c[18:16] = 3'(cch - 1);
        c[14:12] = 3'(ab / 4 - 1);
        c[10:8]  = 3'(cb / 4 - 1);
        c[7:6]   = 2'(ex);
        c[5:4]   = 2'(st);
        c[3]     = 1'(rep);
        c[2]     = 1'(dir);
        c[1]     = 1'(tr);
        c[0]     = 1'(mo);
        return c;
    endfunction

    task automatic cycle(bit allow_new, int inpct, int outpct);
        @(negedge clk);
        if (!in_valid || in_fired) begin
            in_valid = 1'b0;
            if (allow_new && int'($urandom % 100) < inpct) begin
                in_valid = 1'b1;
                in_data = (dq.size() > 0) ? dq.pop_front() : $urandom;
            end
        end
        out_ready = int'($urandom % 100) < outpct;
        #1;
        in_fired = in_valid && in_ready;
        if (in_fired) m_in(in_data);
        if (out_valid && out_ready) begin
            if (q_d.size() == 0) chk(tag, "unexpected beat", 32'd1, 32'd0);
            else begin
                chk(tag, "data", out_data, q_d.pop_front());
                chk(tag, "last", {31'd0, out_last}, {31'd0, q_l.pop_front()});
            end
        end
    endtask

    task automatic run(string t, logic [31:0] c, int cycles, int inpct, int outpct);
        int ach, cch, ab, cb;
        tag = t;
        cfg = c;
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = 0; in_fired = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ach = int'(c[26:24]) + 1; cch = int'(c[18:16]) + 1;
        ab = 4 * (int'(c[14:12]) + 1); cb = 4 * (int'(c[10:8]) + 1);
        m_in_n = c[2] ? cch : ach;  m_out_n = c[2] ? ach : cch;
        m_win  = c[2] ? cb : ab;    m_wout  = c[2] ? ab : cb;
        m_exp = int'(c[7:6]); m_sel = int'(c[5:4]); m_chop = c[1]; m_mono = c[0];
        m_mode = (m_in_n == 2 && m_out_n == 1) ? 1 : (m_in_n == 1 && m_out_n == 2) ? 2 : 0;
        m_lfsr = 16'hACE1; m_hv = 0; m_pcnt = 0;
        q_d.delete(); q_l.delete();
        @(posedge clk);
        @(negedge clk);
        // R1: idle after reset
        chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);
        for (int i = 0; i < cycles; i++) cycle(1'b1, inpct, outpct);
        for (int i = 0; i < 300 && (q_d.size() > 0 || out_valid || (in_valid && !in_fired)); i++)
            cycle(1'b0, 0, 100);
        chk(t, "beats left undelivered", q_d.size(), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R2 equal width, R9 frames of two
        run("R2", mk(2, 2, 24, 24, 0, 0, 0, 0, 0, 0, 0), 300, 70, 70);
        // R3 widen with zeros, then with ones
        run("R3", mk(1, 1, 16, 24, 0, 0, 0, 0, 0, 0, 0), 200, 70, 70);
        run("R3", mk(1, 1, 16, 24, 1, 0, 0, 0, 0, 0, 0), 200, 70, 70);
        // R4 dither fill
        run("R4", mk(1, 1, 8, 32, 2, 0, 0, 0, 0, 0, 0), 300, 80, 80);
        // R5 chop
        run("R5", mk(1, 1, 32, 16, 0, 0, 0, 1, 0, 0, 0), 200, 70, 70);
        // R6 round with saturation corners
        dq = '{32'h7FFF_FF00, 32'h0001_8000, 32'h8000_0000, 32'hFFFF_7F00, 32'h7FFF_7F00};
        run("R6", mk(1, 1, 24, 16, 0, 0, 0, 0, 0, 0, 0), 300, 70, 70);
        // R7 mix-down: first, second, average
        run("R7", mk(2, 1, 16, 16, 0, 0, 0, 0, 0, 0, 0), 200, 70, 70);
        run("R7", mk(2, 1, 16, 16, 0, 1, 0, 0, 0, 0, 0), 200, 70, 70);
        dq = '{32'h7FFF_0000, 32'h7FFF_0000, 32'h8000_0000, 32'h8000_0000, 32'h0001_0000, 32'hFFFF_0000};
        run("R7", mk(2, 1, 16, 16, 0, 2, 0, 0, 0, 0, 0), 300, 70, 70);
        // R8 mono expansion: zero fill, copy, copy of dithered beat
        run("R8", mk(1, 2, 16, 16, 0, 0, 0, 0, 0, 0, 0), 200, 70, 70);
        run("R8", mk(1, 2, 16, 16, 0, 0, 0, 0, 1, 0, 0), 200, 70, 70);
        run("R8", mk(1, 2, 8, 16, 2, 0, 0, 0, 1, 0, 0), 200, 70, 70);
        // R9 unequal counts pass through, frames of five
        run("R9", mk(3, 5, 16, 16, 0, 0, 0, 0, 0, 0, 0), 300, 70, 70);
        // R10 reversed direction: client 1ch/24 in, audio 2ch/16 out
        run("R10", mk(2, 1, 16, 24, 0, 0, 1, 0, 1, 0, 0), 300, 70, 70);
        // R11 threshold and replicate set, same rounding corners
        dq = '{32'h7FFF_FF00, 32'h0001_8000, 32'h8000_0000, 32'hFFFF_7F00};
        run("R11", mk(1, 1, 24, 16, 0, 0, 0, 0, 0, 15, 1), 300, 70, 70);
        // R12 heavy backpressure with dither and pass framing
        run("R12", mk(2, 2, 16, 32, 2, 0, 0, 0, 0, 0, 0), 600, 90, 20);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule